// File: doc/BRIEF.md
# Serial EEPROM Target with Staged Page Writes

This block is an I2C target that behaves like a small serial EEPROM of `MEM_DEPTH` x 8 bits (256 by default, 128 when the parameter is set to 128). A system clock oversamples the SCL and SDA lines. The block finds START and STOP conditions, shifts in the address, word-address and data bytes, and pulls SDA low through an open-drain enable. Data bytes written to it are first gathered in a page buffer of `PAGE_BYTES` entries. They are copied into the array only when the master sends STOP.

After a commit the target stays busy for `WRITE_CYCLES` clocks and does not answer on the bus. A master can therefore poll by repeating its address until it receives an ACK. A write-protect input, sampled once per write session, can reject a whole session. Reads come from an address counter. The counter is set by a dummy write of the word address (random read) or keeps its position from the previous access (current-address read).

Top module: `i2c_eeprom_target`

## Requirements
- R1: Only the 7-bit target address 7'b1010000 (byte 8'hA0 for write, 8'hA1 for read) is acknowledged. Any other address gets no ACK, and the target ignores the bus until the next START.
- R2: After reset every array byte reads 8'hFF. The array is erased during the first `MEM_DEPTH` clocks after reset, and the target acknowledges nothing during that time.
- R3: In a write, the target ACKs the word-address byte and each data byte. The upper bits of the word address choose a 16-byte page. The low 4 bits advance after each data byte and wrap within that page, so a 17th byte overwrites the first.
- R4: The array does not change until STOP. A STOP that follows at least one accepted data byte commits all staged bytes together and starts a busy period of `WRITE_CYCLES` clocks.
- R5: During the busy period SDA stays released and no byte gets an ACK, including the target's own address. After the busy period the address is acknowledged again.
- R6: WP is sampled on the SCL falling edge that ends the word-address ACK clock. If WP is 1 at that edge, the first data byte gets no ACK, nothing is written and no busy period starts.
- R7: WP has no effect when it is 0 at that sample edge, even if it rises later in the session.
- R8: A STOP after the word address with no data byte writes nothing and leaves the target idle and ready. The word address still loads the address counter.
- R9: A read (R/W = 1) returns bytes MSB first starting at the address counter. The counter advances after each byte and wraps from `MEM_DEPTH`-1 to 0. A master ACK asks for another byte; a master NACK ends the transfer.
- R10: A dummy write of the word address, then a repeated START and a read address, returns data starting at that word address.
- R11: The only bus output is `sda_oe_o`, where 1 pulls SDA low. It is 0 during and after reset, and it is 1 only in ACK slots and for 0-bits of read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| wp_i | input | 1 | Write protect, 1 = whole array protected |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
A wrong internal state appears at the bus one byte later at the latest. A wrong pointer in the page buffer shows up as misplaced bytes when the page is read back after the busy period. A busy counter that never loads shows up at once as an ACK on the first poll after STOP. A busy counter that does not clear shows up as polling that never ends. A bad write-protect strobe flips the ACK of the first data byte. A faulty address counter returns the wrong byte on the first read or on the wrap from the top of the array to address 0.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WORD, ST_DATA, ST_ACK, ST_READ, ST_RACK, ST_SKIP
  } bus_state_e;

  typedef enum logic [1:0] {AK_ADDR, AK_WORD, AK_DATA} ack_kind_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic          clearing_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] clr_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing_o <= 1'b1;
      clr_idx    <= '0;
    end else if (clearing_o) begin
      clr_idx <= clr_idx + 1'b1;
      if (clr_idx == AW'(DEPTH - 1)) clearing_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clearing_o) mem[clr_idx] <= 8'hFF;
    else if (we_i)  mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // R2: erase and page commit never compete for the write port
  a_r2_no_commit_during_erase: assert property (@(posedge clk) disable iff (rst)
    clearing_o |-> !we_i);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int AW = 8,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_ld_i,
  input  logic [AW-1:0] base_i,
  input  logic          push_i,
  input  logic [7:0]    push_data_i,
  input  logic          commit_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic          active_o
);
  logic [7:0]       data_q [PAGE_BYTES];
  logic             vld_q  [PAGE_BYTES];
  logic [AW-PW-1:0] page_q;
  logic [PW-1:0]    ptr_q, widx_q;
  logic             walk_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                                vld_q[g] <= 1'b0;
      else if (base_ld_i)                     vld_q[g] <= 1'b0;
      else if (push_i && ptr_q == PW'(g))     vld_q[g] <= 1'b1;
      if (push_i && ptr_q == PW'(g))          data_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      ptr_q  <= '0;
      walk_q <= 1'b0;
      widx_q <= '0;
      we_o   <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      if (base_ld_i) begin
        page_q <= base_i[AW-1:PW];
        ptr_q  <= base_i[PW-1:0];
      end else if (push_i) begin
        ptr_q  <= ptr_q + 1'b1;
      end
      if (commit_i) begin
        walk_q <= 1'b1;
        widx_q <= '0;
      end else if (walk_q) begin
        widx_q <= widx_q + 1'b1;
        if (widx_q == PW'(PAGE_BYTES - 1)) walk_q <= 1'b0;
      end
      we_o    <= walk_q && vld_q[widx_q];
      waddr_o <= {page_q, widx_q};
      wdata_o <= data_q[widx_q];
    end
  end

  assign active_o = walk_q | we_o;

  // R4: the copy into the array only ever follows a commit request
  a_r4_walk_after_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_q) |-> $past(commit_i));
  // R3: pushing data never moves the latched page
  a_r3_page_latched: assert property (@(posedge clk) disable iff (rst)
    (push_i && !base_ld_i) |=> $stable(page_q));
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int         MEM_DEPTH    = 256,
  parameter int         PAGE_BYTES   = 16,
  parameter int         WRITE_CYCLES = 2000,
  parameter logic [6:0] DEV_ADDR     = 7'b1010000,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  import eep_pkg::*;
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int BW = $clog2(WRITE_CYCLES + 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic clearing, commit_active, arr_we;
  logic [AW-1:0] arr_waddr, addr_ctr_q;
  logic [7:0] arr_wdata, rd_data;

  bus_state_e state_q;
  ack_kind_e  kind_q;
  logic [3:0] bcnt_q;
  logic [7:0] shin_q, shout_q;
  logic       rw_q, wp_rej_q, have_data_q, mack_q, sda_oe_q;
  logic [BW-1:0] busy_cnt_q;
  logic busy, ack_fall, word_done, data_push, commit_go, rd_load;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det));

  assign ack_fall  = scl_fall && bcnt_q == 4'd8 &&
                     (state_q == ST_ADDR || state_q == ST_WORD || state_q == ST_DATA);
  assign word_done = ack_fall && state_q == ST_WORD;
  assign data_push = ack_fall && state_q == ST_DATA && !wp_rej_q;
  assign commit_go = stop_det && have_data_q && !wp_rej_q &&
                     (state_q == ST_DATA || state_q == ST_ACK);
  assign rd_load   = scl_fall && ((state_q == ST_ACK && kind_q == AK_ADDR && rw_q) ||
                                  (state_q == ST_RACK && mack_q));
  assign busy      = (busy_cnt_q != '0) || clearing || commit_active;

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) u_page (
    .clk(clk), .rst(rst), .base_ld_i(word_done), .base_i(shin_q[AW-1:0]),
    .push_i(data_push), .push_data_i(shin_q), .commit_i(commit_go),
    .we_o(arr_we), .waddr_o(arr_waddr), .wdata_o(arr_wdata),
    .active_o(commit_active));

  eep_array #(.DEPTH(MEM_DEPTH)) u_array (
    .clk(clk), .rst(rst), .we_i(arr_we), .waddr_i(arr_waddr),
    .wdata_i(arr_wdata), .raddr_i(addr_ctr_q), .rdata_o(rd_data),
    .clearing_o(clearing));

  always_ff @(posedge clk) begin
    if (rst)                    busy_cnt_q <= '0;
    else if (commit_go)         busy_cnt_q <= BW'(WRITE_CYCLES);
    else if (busy_cnt_q != '0)  busy_cnt_q <= busy_cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            addr_ctr_q <= '0;
    else if (word_done) addr_ctr_q <= shin_q[AW-1:0];
    else if (rd_load)   addr_ctr_q <= addr_ctr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE; kind_q <= AK_ADDR; bcnt_q <= '0;
      shin_q <= '0; shout_q <= '0; rw_q <= 1'b0; wp_rej_q <= 1'b0;
      have_data_q <= 1'b0; mack_q <= 1'b0; sda_oe_q <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_ADDR; bcnt_q <= '0; sda_oe_q <= 1'b0;
      have_data_q <= 1'b0; wp_rej_q <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE; sda_oe_q <= 1'b0;
      have_data_q <= 1'b0; wp_rej_q <= 1'b0;
    end else if (rd_load) begin
      shout_q  <= rd_data;
      sda_oe_q <= ~rd_data[7];
      bcnt_q   <= 4'd1;
      state_q  <= ST_READ;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WORD, ST_DATA: begin
          if (scl_rise && bcnt_q != 4'd8) begin
            shin_q <= {shin_q[6:0], sda_s};
            bcnt_q <= bcnt_q + 1'b1;
          end else if (ack_fall) begin
            bcnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (shin_q[7:1] == DEV_ADDR && !busy) begin
                sda_oe_q <= 1'b1; kind_q <= AK_ADDR; rw_q <= shin_q[0];
                state_q  <= ST_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end else if (state_q == ST_WORD) begin
              sda_oe_q <= 1'b1; kind_q <= AK_WORD; state_q <= ST_ACK;
            end else if (!wp_rej_q) begin
              sda_oe_q <= 1'b1; kind_q <= AK_DATA; have_data_q <= 1'b1;
              state_q  <= ST_ACK;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            unique case (kind_q)
              AK_ADDR: state_q <= ST_WORD;
              AK_WORD: begin wp_rej_q <= wp_i; state_q <= ST_DATA; end
              default: state_q <= ST_DATA;
            endcase
          end
        end
        ST_READ: begin
          if (scl_fall) begin
            if (bcnt_q == 4'd8) begin
              sda_oe_q <= 1'b0; state_q <= ST_RACK;
            end else begin
              sda_oe_q <= ~shout_q[6];
              shout_q  <= {shout_q[6:0], 1'b0};
              bcnt_q   <= bcnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise)      mack_q  <= ~sda_s;
          else if (scl_fall) state_q <= ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  // R5: no line drive at all while a write cycle or erase runs
  a_r5_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_cnt_q != '0 || clearing) |-> !sda_oe_q);
  // R4: a busy period only begins at a STOP condition
  a_r4_busy_from_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_cnt_q != '0) |-> $past(stop_det));
  // R6: a rejected session never acknowledges a data byte
  a_r6_protect_no_ack: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && wp_rej_q) |=> !(state_q == ST_ACK && kind_q == AK_DATA));
  // R11: SDA is pulled only in ACK slots or while sending read data
  a_r11_drive_states: assert property (@(posedge clk) disable iff (rst)
    sda_oe_q |-> (state_q == ST_ACK || state_q == ST_READ));
  // R9: the line is released while the master answers a read byte
  a_r9_release_master_ack: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_RACK |-> !sda_oe_q);
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
  localparam int Q = 12;
  localparam int DEPTH = 256;
  localparam int WCYC = 2000;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] wbuf [0:31];
  logic [7:0] rbuf [0:3];

  i2c_eeprom_target #(.MEM_DEPTH(DEPTH), .WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
    .sda_oe_o(sda_oe));

  always #10 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(posedge clk); #1; endtask

  task automatic i2c_start();
    sda_m = 1; qw(); scl = 1; qw(); sda_m = 0; qw(); scl = 0; qw();
  endtask
  task automatic i2c_stop();
    sda_m = 0; qw(); scl = 1; qw(); sda_m = 1; qw();
  endtask
  task automatic put_bit(input bit b);
    sda_m = b; qw(); scl = 1; qw(); qw(); scl = 0; qw();
  endtask
  task automatic get_bit(output bit b);
    sda_m = 1; qw(); scl = 1; qw(); b = sda_line; qw(); scl = 0; qw();
  endtask
  task automatic tx(input logic [7:0] v, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = (b == 1'b0);
  endtask
  task automatic rx(input bit more, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(!more);
  endtask

  task automatic poll(output int nacks);
    bit a;
    nacks = 0;
    for (int i = 0; i < 60; i++) begin
      i2c_start(); tx(8'hA0, a); i2c_stop();
      if (a) break;
      nacks++;
    end
  endtask

  task automatic write_bytes(input logic [7:0] addr, input int n, input string req);
    bit a;
    i2c_start();
    tx(8'hA0, a); chk({req, " address ack"}, a, 1);
    tx(addr, a);  chk({req, " word ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      tx(wbuf[i], a);
      if (!a) chk({req, " data ack"}, a, 1);
    end
    i2c_stop();
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n);
    bit a;
    i2c_start();
    tx(8'hA0, a); tx(addr, a);
    i2c_start();
    tx(8'hA1, a); chk("R10 read address ack", a, 1);
    for (int i = 0; i < n; i++) rx(i != n - 1, rbuf[i]);
    i2c_stop();
  endtask

  task automatic cur_read();
    bit a;
    i2c_start();
    tx(8'hA1, a); chk("R9 current read ack", a, 1);
    rx(1'b0, rbuf[0]);
    i2c_stop();
  endtask

  task automatic t_reset();
    int n;
    rst = 1; repeat (5) @(posedge clk); #1;
    chk("R11 oe low in reset", sda_oe, 0);
    rst = 0;
    repeat (20) @(posedge clk); #1;
    chk("R11 oe low after reset", sda_oe, 0);
    poll(n);
    rand_read(8'h00, 2);
    chk("R2 erased 00", rbuf[0], 8'hFF);
    chk("R2 erased 01", rbuf[1], 8'hFF);
    rand_read(8'hC3, 1);
    chk("R2 erased C3", rbuf[0], 8'hFF);
  endtask

  task automatic t_byte_write();
    int n;
    wbuf[0] = 8'hA5;
    write_bytes(8'h10, 1, "R3 R7 byte write");
    poll(n);
    chk("R5 busy refuses address", int'(n >= 1), 1);
    chk("R5 busy ends", int'(n < 60), 1);
    rand_read(8'h10, 2);
    chk("R4 byte committed", rbuf[0], 8'hA5);
    chk("R4 neighbour untouched", rbuf[1], 8'hFF);
  endtask

  task automatic t_page_wrap();
    int n;
    for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h40 + i);
    write_bytes(8'h2E, 18, "R3 page write");
    poll(n);
    chk("R4 page busy", int'(n >= 1), 1);
    rand_read(8'h2E, 2);
    chk("R3 wrap overwrite 2E", rbuf[0], 8'h50);
    chk("R3 wrap overwrite 2F", rbuf[1], 8'h51);
    rand_read(8'h20, 1);
    chk("R3 wrapped to page start", rbuf[0], 8'h42);
    rand_read(8'h2D, 1);
    chk("R3 last in page", rbuf[0], 8'h4F);
    rand_read(8'h30, 1);
    chk("R3 next page untouched", rbuf[0], 8'hFF);
  endtask

  task automatic t_wp_reject();
    bit a; int n;
    wp = 1;
    i2c_start();
    tx(8'hA0, a); chk("R6 address ack", a, 1);
    tx(8'h50, a); chk("R6 word ack", a, 1);
    tx(8'h99, a); chk("R6 data refused", a, 0);
    i2c_stop();
    wp = 0;
    poll(n);
    chk("R6 not busy", n, 0);
    rand_read(8'h50, 1);
    chk("R6 array unchanged", rbuf[0], 8'hFF);
  endtask

  task automatic t_wp_late();
    bit a; int n;
    i2c_start();
    tx(8'hA0, a); tx(8'h60, a);
    tx(8'h12, a); chk("R7 first byte ack", a, 1);
    wp = 1;
    tx(8'h34, a); chk("R7 late protect ignored", a, 1);
    i2c_stop();
    wp = 0;
    poll(n);
    chk("R7 write cycle ran", int'(n >= 1), 1);
    rand_read(8'h60, 2);
    chk("R7 byte 60", rbuf[0], 8'h12);
    chk("R7 byte 61", rbuf[1], 8'h34);
  endtask

  task automatic t_wrong_addr();
    bit a;
    i2c_start();
    tx(8'hA2, a); chk("R1 foreign address refused", a, 0);
    tx(8'hA0, a); chk("R1 ignored until START", a, 0);
    i2c_stop();
    i2c_start();
    tx(8'hA0, a); chk("R1 own address ack", a, 1);
    i2c_stop();
  endtask

  task automatic t_stop_no_data();
    bit a; int n;
    wbuf[0] = 8'h5A;
    write_bytes(8'h77, 1, "R8 setup");
    poll(n);
    i2c_start(); tx(8'hA0, a); tx(8'h77, a); i2c_stop();
    poll(n);
    chk("R8 no busy after bare address", n, 0);
    cur_read();
    chk("R8 R9 counter from word address", rbuf[0], 8'h5A);
  endtask

  task automatic t_seq_wrap();
    int n;
    wbuf[0] = 8'h11; wbuf[1] = 8'h77;
    write_bytes(8'h00, 2, "R9 setup low");
    poll(n);
    wbuf[0] = 8'h3C;
    write_bytes(8'hFF, 1, "R9 setup top");
    poll(n);
    rand_read(8'hFF, 2);
    chk("R10 random read top", rbuf[0], 8'h3C);
    chk("R9 counter wraps to 00", rbuf[1], 8'h11);
    cur_read();
    chk("R9 current address after wrap", rbuf[0], 8'h77);
  endtask

  initial begin
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_wp_reject();
    t_wp_late();
    t_wrong_addr();
    t_stop_no_data();
    t_seq_wrap();
    summary();
  end
endmodule